// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block manages a bank of 16 general-purpose pins through a small synchronous register bus. A 32-bit control word holds two bits per pin. The even bit of each pair picks the pin direction and the odd bit picks whether a weak pull-up is asked for. A 16-bit output latch supplies the value for every pin that is set as an output. For each pin the block drives three signals toward the pad ring: an output value, an output enable and a pull-up request. The pull-up request is always dropped while the pin is an output.

A read of the data word mixes two sources bit by bit. Output pins return their latched value. Input pins return the pin level after a two-flop synchronizer on the bus clock. The output latch has no reset at all. Its contents survive every reset, so software can preload values before it turns pins into outputs.

The control word sits at word address 0 and the data word at word address 1. A write takes effect on the clock edge where the write strobe is high. Read data is registered. It appears one cycle after the read strobe and holds until the next read.

Top module: `pinbank_port`

## Requirements
- R1: While reset is asserted, and after it is released, the control word is all zeros. Every pin is then an input (`pin_oe` = 0) with its pull-up requested (`pin_pu` = all ones), and a control read returns 0.
- R2: Control bit 2n sets the direction of pin n: 1 is output and 0 is input. `pin_oe[n]` follows the written value on the cycle after a control write.
- R3: Control bit 2n+1 clears the pull-up of an input pin n: 0 requests the pull-up and 1 withholds it. `pin_pu` follows on the cycle after a control write.
- R4: `pin_pu[n]` is 0 whenever pin n is an output, whatever the value of control bit 2n+1.
- R5: A write to address 1 stores `bus_wdata[15:0]` into all 16 latch bits, including the bits of input pins. `pin_out` shows the latch on the next cycle.
- R6: On a data read, each bit whose pin is an output returns the latched value. Bits 31:16 read as 0.
- R7: On a data read, each bit whose pin is an input returns `pin_in` after two synchronizer flops. A level applied at least two clock edges before the edge that samples the read strobe is returned. A level applied only one edge before it is not yet returned.
- R8: `bus_rdata` is loaded on the edge that samples `bus_rd` and keeps its value while `bus_rd` is low.
- R9: A control read returns the full 32-bit control word as last written.
- R10: A read of any address other than 0 and 1 returns 0. A write to such an address changes neither register.
- R11: No reset alters the output latch. `pin_out` keeps its value through an asserted reset and after it.
- R12: When a read and a write to the same register fall in one cycle, the read returns the contents before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address (0 control, 1 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output value per pin (output latch) |
| pin_oe | output | 16 | Output enable per pin |
| pin_pu | output | 16 | Pull-up request per pin |

## Verification
A register read and a register write can fall in the same cycle and hit the same word. Both kinds of collision are provoked. For the data word, the bench raises both strobes together; for the control word, a write that flips every pin to output is combined with a control read. In each case the returned value must be the pre-write contents, and the next read or the pin outputs must already show the write. A second overlap is between a pin changing level and a data read that follows one or two cycles later. There the synchronizer depth decides whether the old level or the new one comes back.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;

  localparam int unsigned PB_BITS_PER_PIN = 2;

  typedef enum logic [1:0] {
    PB_SEL_NONE = 2'd0,
    PB_SEL_CTRL = 2'd1,
    PB_SEL_DATA = 2'd2
  } pb_sel_e;

endpackage

// File: rtl/pinbank_rst_sync.sv
`timescale 1ns/1ps
module pinbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_regs.sv
`timescale 1ns/1ps
module pinbank_regs #(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic               data_we,
  input  logic [2*NPINS-1:0] wdata,
  output logic [2*NPINS-1:0] ctrl_q,
  output logic [NPINS-1:0]   latch_q,
  output logic [NPINS-1:0]   oe,
  output logic [NPINS-1:0]   pu
);

  localparam int unsigned CW = 2 * NPINS;

  logic [CW-1:0]    ctrl_d;
  logic [NPINS-1:0] latch_d;

  // next-state
  always_comb begin
    ctrl_d  = ctrl_we ? wdata : ctrl_q;
    latch_d = data_we ? wdata[NPINS-1:0] : latch_q;
  end

  // control word: cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // output latch: deliberately outside every reset
  always_ff @(posedge clk) begin
    latch_q <= latch_d;
  end

  // per-pin decode of the interleaved control pairs
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic dir_bit;
    logic pull_off_bit;
    assign dir_bit      = ctrl_q[2*p];
    assign pull_off_bit = ctrl_q[2*p+1];
    assign oe[p]        = dir_bit;
    assign pu[p]        = ~pull_off_bit & ~dir_bit;
  end

endmodule

// File: rtl/pinbank_rdport.sv
`timescale 1ns/1ps
module pinbank_rdport
  import pinbank_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  pb_sel_e            sel,
  input  logic [2*NPINS-1:0] ctrl_q,
  input  logic [NPINS-1:0]   latch_q,
  input  logic [NPINS-1:0]   oe,
  input  logic [NPINS-1:0]   pin_sync,
  output logic [2*NPINS-1:0] rdata
);

  localparam int unsigned DW = 2 * NPINS;

  logic [NPINS-1:0] mix;
  logic [DW-1:0]    rd_word;
  logic [DW-1:0]    rdata_d;
  logic [DW-1:0]    rdata_q;

  for (genvar b = 0; b < NPINS; b++) begin : g_mix
    assign mix[b] = oe[b] ? latch_q[b] : pin_sync[b];
  end

  always_comb begin
    unique case (sel)
      PB_SEL_CTRL: rd_word = ctrl_q;
      PB_SEL_DATA: rd_word = {{(DW-NPINS){1'b0}}, mix};
      default:     rd_word = '0;
    endcase
    rdata_d = rd_en ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/pinbank_port.sv
`timescale 1ns/1ps
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned AW          = 4,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned DATA_ADDR   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [AW-1:0]        bus_addr,
  input  logic [2*NPINS-1:0]   bus_wdata,
  output logic [2*NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic [NPINS-1:0]     pin_pu
);

  localparam int unsigned DW = PB_BITS_PER_PIN * NPINS;
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] DATA_A = AW'(DATA_ADDR);

  logic             rst_sync_n;
  pb_sel_e          sel;
  logic             ctrl_we;
  logic             data_we;
  logic [DW-1:0]    ctrl_q;
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] pin_sync;

  pinbank_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode
  always_comb begin
    if (bus_addr == CTRL_A)      sel = PB_SEL_CTRL;
    else if (bus_addr == DATA_A) sel = PB_SEL_DATA;
    else                         sel = PB_SEL_NONE;
    ctrl_we = bus_wr && (sel == PB_SEL_CTRL);
    data_we = bus_wr && (sel == PB_SEL_DATA);
  end

  pinbank_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  pinbank_regs #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctrl_we (ctrl_we),
    .data_we (data_we),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .latch_q (latch_q),
    .oe      (pin_oe),
    .pu      (pin_pu)
  );

  pinbank_rdport #(.NPINS(NPINS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (bus_rd),
    .sel      (sel),
    .ctrl_q   (ctrl_q),
    .latch_q  (latch_q),
    .oe       (pin_oe),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign pin_out = latch_q;

endmodule

// File: rtl/pinbank_chk.sv
`timescale 1ns/1ps
module pinbank_chk #(
  parameter int unsigned NPINS     = 16,
  parameter int unsigned AW        = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned DATA_ADDR = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [AW-1:0]      bus_addr,
  input logic [2*NPINS-1:0] bus_wdata,
  input logic [2*NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_oe,
  input logic [NPINS-1:0]   pin_pu
);

  logic [NPINS-1:0] wr_dir;
  logic [NPINS-1:0] wr_pull_off;
  logic             hit_ctrl;
  logic             hit_data;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      wr_dir[i]      = bus_wdata[2*i];
      wr_pull_off[i] = bus_wdata[2*i+1];
    end
    hit_ctrl = (bus_addr == AW'(CTRL_ADDR));
    hit_data = (bus_addr == AW'(DATA_ADDR));
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_pu == '1));

  assert_dir_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_ctrl) |=> (pin_oe == $past(wr_dir)));

  assert_pull_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_ctrl) |=> (pin_pu == $past(~wr_dir & ~wr_pull_off)));

  assert_pull_off_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & pin_pu) == '0));

  assert_latch_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_data) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_ctrl && !hit_data) |=> (bus_rdata == '0));

  assert_latch_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_data) |=> $stable(pin_out));

endmodule

bind pinbank_port pinbank_chk #(
  .NPINS     (NPINS),
  .AW        (AW),
  .CTRL_ADDR (CTRL_ADDR),
  .DATA_ADDR (DATA_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_pu    (pin_pu)
);

// File: tb/pinbank_port_bench.sv
`timescale 1ns/1ps
module pinbank_port_bench;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_DATA = 4'd1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic [15:0] pin_pu;

  always #5 clk = ~clk;

  pinbank_port u_pinbank_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu)
  );

  typedef struct {
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start right after a falling edge
  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [31:0] e, string r);
    exp_t it;
    it.val = e; it.req = r;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_rdwr(logic [3:0] a, logic [31:0] d, logic [31:0] e, string r);
    exp_t it;
    it.val = e; it.req = r;
    sb.push_back(it);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // monitor: scoreboard compare one cycle after each sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          chk("R8 unexpected read", bus_rdata, 32'hxxxx_xxxx);
        end else begin
          e = sb.pop_front();
          chk(e.req, bus_rdata, e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 pu", {16'h0, pin_pu}, 32'h0000_FFFF);
    bus_read(A_CTRL, 32'h0, "R1 ctrl read");

    // R2/R4/R9: low byte outputs, pulls requested everywhere
    bus_write(A_CTRL, 32'h0000_5555);
    chk("R2 oe", {16'h0, pin_oe}, 32'h0000_00FF);
    chk("R4 pu forced off", {16'h0, pin_pu}, 32'h0000_FF00);
    bus_read(A_CTRL, 32'h0000_5555, "R9 ctrl read");

    // R3: pull-off bits on pins 0,1 and 8..15, all inputs
    bus_write(A_CTRL, 32'hAAAA_000A);
    chk("R3 pu", {16'h0, pin_pu}, 32'h0000_00FC);
    chk("R2 oe inputs", {16'h0, pin_oe}, 32'h0);

    // R4: pins 0,1 outputs with pull bits 0
    bus_write(A_CTRL, 32'h0000_0005);
    chk("R4 pu", {16'h0, pin_pu}, 32'h0000_FFFC);
    chk("R2 oe", {16'h0, pin_oe}, 32'h0000_0003);

    // R5: latch written while all pins are inputs
    bus_write(A_CTRL, 32'h0);
    bus_write(A_DATA, 32'hFFFF_3C5A);
    chk("R5 pin_out", {16'h0, pin_out}, 32'h0000_3C5A);
    bus_write(A_CTRL, 32'h5555_5555);
    bus_read(A_DATA, 32'h0000_3C5A, "R6 data read outputs");

    // R7: input sampling and synchronizer depth
    bus_write(A_CTRL, 32'h0);
    pin_in = 16'hBEEF;
    repeat (2) @(negedge clk);
    bus_read(A_DATA, 32'h0000_BEEF, "R7 settled input");
    pin_in = 16'h1111;
    @(negedge clk);
    bus_read(A_DATA, 32'h0000_BEEF, "R7 too early");
    bus_read(A_DATA, 32'h0000_1111, "R7 two edges");

    // R6/R7 mixed directions
    bus_write(A_DATA, 32'h0000_FF00);
    pin_in = 16'h0F0F;
    bus_write(A_CTRL, 32'h0000_5555);
    @(negedge clk);
    bus_read(A_DATA, 32'h0000_0F00, "R6 R7 mixed");

    // R8: hold without strobe
    repeat (3) @(negedge clk);
    chk("R8 hold", bus_rdata, 32'h0000_0F00);

    // R10: unmapped addresses
    bus_read(4'h7, 32'h0, "R10 unmapped read");
    bus_write(4'h9, 32'hFFFF_FFFF);
    chk("R10 latch untouched", {16'h0, pin_out}, 32'h0000_FF00);
    bus_read(A_CTRL, 32'h0000_5555, "R10 ctrl untouched");

    // R12: same-cycle read and write
    bus_rdwr(A_DATA, 32'h0000_1234, 32'h0000_0F00, "R12 data old value");
    bus_read(A_DATA, 32'h0000_0F34, "R12 data new value");
    bus_rdwr(A_CTRL, 32'hFFFF_FFFF, 32'h0000_5555, "R12 ctrl old value");
    chk("R12 ctrl applied", {16'h0, pin_oe}, 32'h0000_FFFF);

    // R11: latch survives reset
    bus_write(A_DATA, 32'h0000_A5C3);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 during reset", {16'h0, pin_out}, 32'h0000_A5C3);
    chk("R1 oe in reset", {16'h0, pin_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 after reset", {16'h0, pin_out}, 32'h0000_A5C3);
    bus_write(A_CTRL, 32'h5555_5555);
    bus_read(A_DATA, 32'h0000_A5C3, "R11 read after reset");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R8 pending: actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule